// File: doc/BRIEF.md
# Direct-Mapped Cache Controller

The block is a single-level, direct-mapped cache placed between a processor word port and a main-memory word port. By default it holds 128 lines of 16 words of 32 bits. Each line keeps a tag, a valid flag and a dirty flag. The processor presents one word access at a time and receives a one-cycle completion pulse. Main memory is reached one word per request over a request/acknowledge handshake.

A mode input selects between write-through and write-back behaviour. In write-through mode every write goes to memory and a write miss allocates no line. In write-back mode writes stay in the cache until the line is evicted, and a write miss first fills the line. On a read miss the line is fetched at ascending word offsets. The requested word is handed to the processor in the cycle it arrives, and the rest of the line keeps loading.

Two maintenance paths keep memory and cache consistent around DMA traffic. A snoop port names a memory word that an external agent has written, and a resident copy of that block is invalidated. A flush command walks every line and writes each dirty line back to memory.

Top module: `dmc_top`

## Requirements
- R1: A 16-bit word address splits into tag = addr[15:11], line index = addr[10:4] and word offset = addr[3:0]. After reset no line is valid or dirty, so the first access to any block misses, and all fill traffic for it targets memory block addr[15:4].
- R2: A read hits only when the indexed line is valid and its stored tag equals the address tag. A read hit raises cpu_ready one cycle after acceptance, with the cached word and no memory request.
- R3: A block can live only in line (block number mod 128). A miss to another block with the same index replaces the resident block, and a later access to the old block misses again.
- R4: With wb_mode=0 every processor write issues exactly one memory write of that word. A write hit also updates the cached copy. A write miss allocates nothing, so a later read of that address misses.
- R5: With wb_mode=1 a write hit updates only the cache, marks the line dirty and issues no memory access. When that line is evicted, all 16 of its words are written back to memory before the new block is fetched.
- R6: With wb_mode=1 a write miss fetches the whole block into the line, then overwrites the addressed word. It completes with no memory write, and the line is left dirty.
- R7: On a read miss, cpu_ready and cpu_rdata are driven in the same cycle as the mem_ack that returns the requested offset. No further ready pulse follows for that request.
- R8: Line fills and write-backs move the words at offsets 0 to 15 in ascending order, one word per handshake. A victim write-back always runs in full before the fill of the new block starts.
- R9: A snoop to a word whose block is resident clears that line's valid and dirty flags, so the next access to it misses and reads memory. A snoop to a block that is not resident changes nothing. snoop_ack pulses once per snoop. A snoop presented in the same cycle as a processor request is served first.
- R10: A flush writes back every valid dirty line, 16 words each, and clears their dirty flags, then pulses flush_done. A flush with no dirty lines finishes with no memory traffic.
- R11: cpu_ready is a one-cycle pulse. A new processor request, held on cpu_req, is accepted only when the controller is idle and not in its completion cycle.
- R12: mem_req, mem_we and mem_addr hold steady from the start of a memory request until its mem_ack. mem_rdata is taken in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wb_mode | input | 1 | 1 selects write-back, 0 selects write-through |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | 16 | Processor word address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| mem_req | output | 1 | Memory word request, held until mem_ack |
| mem_we | output | 1 | 1 for a memory write |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completion, one cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| snoop_valid | input | 1 | External write reported, held until snoop_ack |
| snoop_addr | input | 16 | Word address written by the external agent |
| snoop_ack | output | 1 | Snoop handled, one-cycle pulse |
| flush_req | input | 1 | Flush command, held until flush_done |
| flush_done | output | 1 | Flush complete, one-cycle pulse |

## Verification
Faults in the tag, valid or dirty state show up at the memory port before they reach the data. A lost dirty flag shows as an eviction that writes too few words, or as a flush with no traffic. A stale valid flag shows as a hit with no memory request when 16 reads are expected. Each access is checked in the cycle it completes, using the count and order of memory handshakes it caused, so a wrong flag is caught on the first access to its line. Forwarding faults are caught in the acknowledge cycle of the requested offset.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WTWR  = 3'd1,
      ST_EVICT = 3'd2,
      ST_FILL  = 3'd3,
      ST_SCAN  = 3'd4
   } dmc_state_e;
endpackage

// File: rtl/dmc_tag_array.sv
module dmc_tag_array #(
   parameter int IDX_W = 7,
   parameter int TAG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic             rd_dirty,
   output logic [TAG_W-1:0] rd_tag,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic             upd_valid,
   input  logic             upd_dirty,
   input  logic [TAG_W-1:0] upd_tag,
   output logic [(1<<IDX_W)-1:0] dirty_vec
);
   localparam int LINES = 1 << IDX_W;

   if (IDX_W < 1 || TAG_W < 1) begin : g_bad_cfg
      $error("dmc_tag_array: index and tag widths must be positive");
   end

   logic [LINES-1:0] valid_q;
   logic [LINES-1:0] dirty_q;
   logic [TAG_W-1:0] tag_q [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q[g] <= 1'b0;
            dirty_q[g] <= 1'b0;
         end else if (upd_en && upd_idx == IDX_W'(g)) begin
            valid_q[g] <= upd_valid;
            dirty_q[g] <= upd_dirty;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (upd_en) tag_q[upd_idx] <= upd_tag;
   end

   assign rd_valid  = valid_q[rd_idx];
   assign rd_dirty  = dirty_q[rd_idx];
   assign rd_tag    = tag_q[rd_idx];
   assign dirty_vec = dirty_q;
endmodule

// File: rtl/dmc_data_array.sv
module dmc_data_array #(
   parameter int AW     = 11,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int DEPTH = 1 << AW;

   if (AW < 1 || DATA_W < 1) begin : g_bad_cfg
      $error("dmc_data_array: widths must be positive");
   end

   logic [DATA_W-1:0] word_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) word_q[wr_addr] <= wr_data;
   end

   assign rd_data = word_q[rd_addr];
endmodule

// File: rtl/dmc_top.sv
module dmc_top #(
   parameter int ADDR_W = 16,
   parameter int IDX_W  = 7,
   parameter int OFF_W  = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wb_mode,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              snoop_valid,
   input  logic [ADDR_W-1:0] snoop_addr,
   output logic              snoop_ack,
   input  logic              flush_req,
   output logic              flush_done
);
   import dmc_pkg::*;

   localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
   localparam int LINES = 1 << IDX_W;
   localparam int DA_W  = IDX_W + OFF_W;

   if (TAG_W < 1) begin : g_bad_split
      $error("dmc_top: address too narrow for index and offset");
   end

   // address fields
   logic [TAG_W-1:0] cpu_tag, snp_tag;
   logic [IDX_W-1:0] cpu_idx, snp_idx;
   logic [OFF_W-1:0] cpu_off;
   assign {cpu_tag, cpu_idx, cpu_off} = cpu_addr;
   assign snp_tag = snoop_addr[ADDR_W-1 -: TAG_W];
   assign snp_idx = snoop_addr[OFF_W +: IDX_W];

   // state
   dmc_state_e        state_q;
   logic              ready_q, snoop_ack_q, flush_done_q, flush_q;
   logic              req_we_q;
   logic [TAG_W-1:0]  req_tag_q, ev_tag_q;
   logic [IDX_W-1:0]  line_q;
   logic [OFF_W-1:0]  req_off_q, cnt_q;
   logic [DATA_W-1:0] req_wdata_q, rdata_q;

   // tag array
   logic              t_valid, t_dirty;
   logic [TAG_W-1:0]  t_tag;
   logic [IDX_W-1:0]  rd_idx;
   logic              upd_en, upd_valid, upd_dirty;
   logic [IDX_W-1:0]  upd_idx;
   logic [TAG_W-1:0]  upd_tag;
   logic [LINES-1:0]  dirty_all;

   // data array
   logic [DA_W-1:0]   d_raddr, d_waddr;
   logic [DATA_W-1:0] d_rdata, d_wdata;
   logic              d_we;

   logic in_idle, take_snp, take_fl, take_cpu, look_hit;
   logic last_word, last_line, fwd;

   assign in_idle   = (state_q == ST_IDLE);
   assign take_snp  = in_idle && snoop_valid && !snoop_ack_q;
   assign take_fl   = in_idle && !take_snp && flush_req && !flush_done_q;
   assign take_cpu  = in_idle && !take_snp && !take_fl && cpu_req && !ready_q;
   assign rd_idx    = !in_idle ? line_q : (take_snp ? snp_idx : cpu_idx);
   assign look_hit  = t_valid && (t_tag == (take_snp ? snp_tag : cpu_tag));
   assign last_word = &cnt_q;
   assign last_line = &line_q;

   dmc_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (rd_idx),
      .rd_valid (t_valid),
      .rd_dirty (t_dirty),
      .rd_tag   (t_tag),
      .upd_en   (upd_en),
      .upd_idx  (upd_idx),
      .upd_valid(upd_valid),
      .upd_dirty(upd_dirty),
      .upd_tag  (upd_tag),
      .dirty_vec(dirty_all)
   );

   dmc_data_array #(.AW(DA_W), .DATA_W(DATA_W)) i_data (
      .clk    (clk),
      .rd_addr(d_raddr),
      .rd_data(d_rdata),
      .wr_en  (d_we),
      .wr_addr(d_waddr),
      .wr_data(d_wdata)
   );

   // tag/flag update selection
   always_comb begin
      upd_en    = 1'b0;
      upd_idx   = line_q;
      upd_valid = t_valid;
      upd_dirty = t_dirty;
      upd_tag   = t_tag;
      if (take_snp && look_hit) begin
         upd_en    = 1'b1;
         upd_idx   = snp_idx;
         upd_valid = 1'b0;
         upd_dirty = 1'b0;
      end else if (take_cpu && look_hit && cpu_we && wb_mode) begin
         upd_en    = 1'b1;
         upd_idx   = cpu_idx;
         upd_dirty = 1'b1;
      end else if (state_q == ST_FILL && mem_ack && last_word) begin
         upd_en    = 1'b1;
         upd_valid = 1'b1;
         upd_dirty = req_we_q;
         upd_tag   = req_tag_q;
      end else if (state_q == ST_EVICT && mem_ack && last_word && flush_q) begin
         upd_en    = 1'b1;
         upd_dirty = 1'b0;
      end
   end

   // data array ports
   assign d_raddr = in_idle ? {cpu_idx, cpu_off} : {line_q, cnt_q};
   assign d_we    = (take_cpu && look_hit && cpu_we) || (state_q == ST_FILL && mem_ack);
   assign d_waddr = in_idle ? {cpu_idx, cpu_off} : {line_q, cnt_q};
   always_comb begin
      if (in_idle)                            d_wdata = cpu_wdata;
      else if (req_we_q && cnt_q == req_off_q) d_wdata = req_wdata_q;
      else                                     d_wdata = mem_rdata;
   end

   // memory port
   assign mem_req = (state_q == ST_WTWR) || (state_q == ST_EVICT) || (state_q == ST_FILL);
   assign mem_we  = (state_q == ST_WTWR) || (state_q == ST_EVICT);
   always_comb begin
      case (state_q)
         ST_WTWR:  mem_addr = {req_tag_q, line_q, req_off_q};
         ST_EVICT: mem_addr = {ev_tag_q,  line_q, cnt_q};
         default:  mem_addr = {req_tag_q, line_q, cnt_q};
      endcase
   end
   assign mem_wdata = (state_q == ST_WTWR) ? req_wdata_q : d_rdata;

   // processor port with load-through
   assign fwd       = (state_q == ST_FILL) && mem_ack && !req_we_q && (cnt_q == req_off_q);
   assign cpu_ready = ready_q || fwd;
   assign cpu_rdata = fwd ? mem_rdata : rdata_q;
   assign snoop_ack  = snoop_ack_q;
   assign flush_done = flush_done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         ready_q      <= 1'b0;
         snoop_ack_q  <= 1'b0;
         flush_done_q <= 1'b0;
         flush_q      <= 1'b0;
         req_we_q     <= 1'b0;
         req_tag_q    <= '0;
         ev_tag_q     <= '0;
         line_q       <= '0;
         req_off_q    <= '0;
         cnt_q        <= '0;
         req_wdata_q  <= '0;
         rdata_q      <= '0;
      end else begin
         ready_q      <= 1'b0;
         snoop_ack_q  <= 1'b0;
         flush_done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (take_snp) begin
                  snoop_ack_q <= 1'b1;
               end else if (take_fl) begin
                  flush_q <= 1'b1;
                  line_q  <= '0;
                  cnt_q   <= '0;
                  state_q <= ST_SCAN;
               end else if (take_cpu) begin
                  flush_q     <= 1'b0;
                  req_we_q    <= cpu_we;
                  req_tag_q   <= cpu_tag;
                  req_off_q   <= cpu_off;
                  req_wdata_q <= cpu_wdata;
                  line_q      <= cpu_idx;
                  ev_tag_q    <= t_tag;
                  cnt_q       <= '0;
                  if (look_hit) begin
                     if (!cpu_we) begin
                        ready_q <= 1'b1;
                        rdata_q <= d_rdata;
                     end else if (wb_mode) begin
                        ready_q <= 1'b1;
                     end else begin
                        state_q <= ST_WTWR;
                     end
                  end else if (cpu_we && !wb_mode) begin
                     state_q <= ST_WTWR;
                  end else if (t_valid && t_dirty) begin
                     state_q <= ST_EVICT;
                  end else begin
                     state_q <= ST_FILL;
                  end
               end
            end
            ST_WTWR: begin
               if (mem_ack) begin
                  ready_q <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            ST_EVICT: begin
               if (mem_ack) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (last_word) begin
                     if (!flush_q) begin
                        state_q <= ST_FILL;
                     end else if (last_line) begin
                        flush_q      <= 1'b0;
                        flush_done_q <= 1'b1;
                        state_q      <= ST_IDLE;
                     end else begin
                        line_q  <= line_q + 1'b1;
                        state_q <= ST_SCAN;
                     end
                  end
               end
            end
            ST_FILL: begin
               if (mem_ack) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (last_word) begin
                     ready_q <= req_we_q;
                     state_q <= ST_IDLE;
                  end
               end
            end
            ST_SCAN: begin
               if (t_valid && t_dirty) begin
                  ev_tag_q <= t_tag;
                  cnt_q    <= '0;
                  state_q  <= ST_EVICT;
               end else if (last_line) begin
                  flush_q      <= 1'b0;
                  flush_done_q <= 1'b1;
                  state_q      <= ST_IDLE;
               end else begin
                  line_q <= line_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // observation points for the bound checker
   logic chk_rd_hit, chk_wb_hit, chk_wt_wr, chk_burst;
   assign chk_rd_hit = take_cpu && look_hit && !cpu_we;
   assign chk_wb_hit = take_cpu && look_hit && cpu_we && wb_mode;
   assign chk_wt_wr  = take_cpu && cpu_we && !wb_mode;
   assign chk_burst  = (state_q == ST_EVICT) || (state_q == ST_FILL);
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 4,
   parameter int LINES  = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              flush_done,
   input logic              snoop_ack,
   input logic [LINES-1:0]  dirty_all,
   input logic              rd_hit,
   input logic              wb_hit,
   input logic              wt_wr,
   input logic              burst
);
   assert_hit_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |=> cpu_ready && !mem_req);

   assert_wt_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wt_wr |=> mem_req && mem_we);

   assert_wb_hit_local_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wb_hit |=> cpu_ready && !mem_req);

   assert_ascending_R8: assert property (@(posedge clk) disable iff (!rst_n)
      burst && mem_ack && (mem_addr[OFF_W-1:0] != {OFF_W{1'b1}})
      |=> burst && mem_addr[OFF_W-1:0] == OFF_W'($past(mem_addr[OFF_W-1:0]) + 1'b1));

   assert_snoop_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_ack |=> !snoop_ack);

   assert_flush_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_done |-> dirty_all == '0);

   assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready);

   assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
endmodule

bind dmc_top dmc_checker #(
   .ADDR_W(ADDR_W),
   .OFF_W (OFF_W),
   .LINES (LINES)
) i_dmc_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_ready (cpu_ready),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_ack   (mem_ack),
   .mem_addr  (mem_addr),
   .flush_done(flush_done),
   .snoop_ack (snoop_ack),
   .dirty_all (dirty_all),
   .rd_hit    (chk_rd_hit),
   .wb_hit    (chk_wb_hit),
   .wt_wr     (chk_wt_wr),
   .burst     (chk_burst)
);

// File: tb/test_dmc_top.sv
module test_dmc_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wb_mode = 1'b0;
   logic        cpu_req = 1'b0;
   logic        cpu_we = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_ready;
   logic [31:0] cpu_rdata;
   logic        mem_req, mem_we;
   logic [15:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        snoop_valid = 1'b0;
   logic [15:0] snoop_addr = '0;
   logic        snoop_ack;
   logic        flush_req = 1'b0;
   logic        flush_done;

   always #4 clk = ~clk;

   dmc_top i_dmc_top (
      .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .snoop_ack(snoop_ack),
      .flush_req(flush_req), .flush_done(flush_done)
   );

   int checks = 0;
   int errors = 0;

   typedef struct { logic [15:0] a; logic we; } xfer_t;
   xfer_t       xlog [$];
   logic [31:0] mem_m [int];
   logic [31:0] ref_m [int];
   logic [31:0] exp_q [$];
   logic        cur_rd = 1'b0;
   int          hs_err = 0;
   int          pulse_err = 0;
   longint      t_snp = 0;
   longint      t_rdy = 0;

   function automatic logic [31:0] initv(input logic [15:0] a);
      return 32'hA500_0000 ^ ({16'h0, a} * 32'h0001_0003);
   endfunction
   function automatic logic [31:0] mem_rd(input logic [15:0] a);
      return mem_m.exists(int'(a)) ? mem_m[int'(a)] : initv(a);
   endfunction
   function automatic logic [31:0] ref_rd(input logic [15:0] a);
      return ref_m.exists(int'(a)) ? ref_m[int'(a)] : initv(a);
   endfunction
   function automatic logic [15:0] mk(input int tg, input int ix, input int of);
      return {tg[4:0], ix[6:0], of[3:0]};
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   // memory model: one ack per request, with one idle cycle between words
   initial begin
      bit gap = 1'b0;
      forever begin
         @(posedge clk); #1;
         if (mem_ack) mem_ack = 1'b0;
         else if (mem_req) begin
            if (!gap) gap = 1'b1;
            else begin
               gap = 1'b0;
               mem_ack = 1'b1;
               xlog.push_back('{a: mem_addr, we: mem_we});
               if (mem_we) mem_m[int'(mem_addr)] = mem_wdata;
               else mem_rdata = mem_rd(mem_addr);
            end
         end
      end
   end

   // scoreboard monitor and port-rule monitors
   initial begin
      logic        prev_pend = 1'b0;
      logic        prev_rdy = 1'b0;
      logic [15:0] prev_a = '0;
      forever begin
         @(negedge clk);
         if (cpu_ready && cur_rd) begin
            logic [31:0] e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hDEAD_DEAD;
            chk(cpu_rdata == e, "R2", "read data", cpu_rdata, e);
         end
         if (prev_pend && (!mem_req || mem_addr != prev_a)) hs_err++;
         if (cpu_ready && prev_rdy) pulse_err++;
         prev_pend = mem_req && !mem_ack;
         prev_a    = mem_addr;
         prev_rdy  = cpu_ready;
      end
   end

   task automatic cpu_op(input logic we, input logic [15:0] a, input logic [31:0] d,
                         output int lat, output bit fw, output int n_at);
      @(negedge clk);
      if (!we) exp_q.push_back(ref_rd(a));
      else ref_m[int'(a)] = d;
      cur_rd = !we; cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      lat = 0;
      do begin @(negedge clk); lat++; end while (!cpu_ready);
      fw = mem_ack; n_at = xlog.size(); t_rdy = $time;
      cpu_req = 1'b0; cur_rd = 1'b0;
   endtask

   task automatic snoop(input logic [15:0] a);
      @(negedge clk);
      snoop_valid = 1'b1; snoop_addr = a;
      do @(negedge clk); while (!snoop_ack);
      t_snp = $time;
      snoop_valid = 1'b0;
   endtask

   task automatic flush();
      @(negedge clk);
      flush_req = 1'b1;
      do @(negedge clk); while (!flush_done);
      flush_req = 1'b0;
   endtask

   function automatic bit burst_ok(input int from, input logic [11:0] blk, input logic we);
      for (int k = 0; k < 16; k++)
         if (xlog[from+k].a != {blk, 4'(k)} || xlog[from+k].we != we) return 1'b0;
      return 1'b1;
   endfunction

   function automatic int count_we();
      int n = 0;
      foreach (xlog[k]) if (xlog[k].we) n++;
      return n;
   endfunction

   initial begin
      #(8 * 150000);
      errors++; checks++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int lat, nat;
      bit fw;
      repeat (3) @(negedge clk);
      chk(!cpu_ready && !mem_req && !snoop_ack && !flush_done, "R1", "reset outputs",
          {cpu_ready, mem_req}, 0);
      rst_n = 1'b1;

      // R1 R7 R8: read miss in write-back mode with load-through
      wb_mode = 1'b1;
      xlog.delete();
      cpu_op(0, mk(1,5,6), 0, lat, fw, nat);
      chk(fw == 1'b1, "R7", "ready with mem_ack", fw, 1);
      chk(nat == 7, "R7", "acks at forward", nat, 7);
      repeat (40) @(negedge clk);
      chk(xlog.size() == 16 && burst_ok(0, {5'd1, 7'd5}, 1'b0), "R8", "fill order", xlog.size(), 16);

      // R2: read hit
      xlog.delete();
      cpu_op(0, mk(1,5,9), 0, lat, fw, nat);
      chk(lat == 1 && xlog.size() == 0, "R2", "hit latency/no mem", lat, 1);

      // R4: write-through write hit
      wb_mode = 1'b0;
      xlog.delete();
      cpu_op(1, mk(1,5,9), 32'h1111_2222, lat, fw, nat);
      chk(xlog.size() == 1 && xlog[0].we && mem_rd(mk(1,5,9)) == 32'h1111_2222, "R4",
          "wt hit mem write", mem_rd(mk(1,5,9)), 32'h1111_2222);
      xlog.delete();
      cpu_op(0, mk(1,5,9), 0, lat, fw, nat);
      chk(xlog.size() == 0, "R4", "wt hit updated cache", xlog.size(), 0);

      // R4: write-through write miss does not allocate
      xlog.delete();
      cpu_op(1, mk(2,6,3), 32'h3333_4444, lat, fw, nat);
      chk(xlog.size() == 1 && mem_rd(mk(2,6,3)) == 32'h3333_4444, "R4", "wt miss mem write",
          xlog.size(), 1);
      xlog.delete();
      cpu_op(0, mk(2,6,3), 0, lat, fw, nat);
      repeat (40) @(negedge clk);
      chk(xlog.size() == 16 && count_we() == 0, "R4", "no allocate on wt miss", xlog.size(), 16);

      // R5: write-back write hit stays in cache
      wb_mode = 1'b1;
      xlog.delete();
      cpu_op(1, mk(1,5,2), 32'hABCD_0001, lat, fw, nat);
      chk(xlog.size() == 0 && mem_rd(mk(1,5,2)) == initv(mk(1,5,2)), "R5", "wb hit local",
          mem_rd(mk(1,5,2)), initv(mk(1,5,2)));

      // R3 R5 R8: conflict miss evicts the dirty victim then fills
      xlog.delete();
      cpu_op(0, mk(3,5,0), 0, lat, fw, nat);
      repeat (80) @(negedge clk);
      chk(xlog.size() == 32 && burst_ok(0, {5'd1, 7'd5}, 1'b1) && burst_ok(16, {5'd3, 7'd5}, 1'b0),
          "R8", "evict then fill", xlog.size(), 32);
      chk(mem_rd(mk(1,5,2)) == 32'hABCD_0001, "R5", "victim word written back",
          mem_rd(mk(1,5,2)), 32'hABCD_0001);
      xlog.delete();
      cpu_op(0, mk(1,5,2), 0, lat, fw, nat);
      repeat (40) @(negedge clk);
      chk(xlog.size() == 16 && count_we() == 0, "R3", "old block replaced", xlog.size(), 16);

      // R6: write-back write miss fills then merges
      xlog.delete();
      cpu_op(1, mk(4,7,5), 32'h5A5A_0005, lat, fw, nat);
      chk(xlog.size() == 16 && count_we() == 0 && mem_rd(mk(4,7,5)) == initv(mk(4,7,5)), "R6",
          "wb miss fill only", xlog.size(), 16);
      xlog.delete();
      cpu_op(0, mk(4,7,5), 0, lat, fw, nat);
      chk(xlog.size() == 0, "R6", "merged word hits", xlog.size(), 0);

      // R9: snoop has priority and invalidates the resident block
      mem_m[int'(mk(1,5,4))] = 32'h0D3A_0004;
      ref_m[int'(mk(1,5,4))] = 32'h0D3A_0004;
      xlog.delete();
      fork
         snoop(mk(1,5,4));
         cpu_op(0, mk(1,5,4), 0, lat, fw, nat);
      join
      chk(t_snp < t_rdy, "R9", "snoop served first", t_snp, t_rdy);
      repeat (40) @(negedge clk);
      chk(xlog.size() == 16, "R9", "invalidated line refetched", xlog.size(), 16);
      snoop(mk(9,5,0));
      xlog.delete();
      cpu_op(0, mk(1,5,4), 0, lat, fw, nat);
      chk(xlog.size() == 0, "R9", "non-resident snoop ignored", xlog.size(), 0);

      // R10: flush writes back every dirty line once
      cpu_op(1, mk(1,5,1), 32'hF1F1_0001, lat, fw, nat);
      xlog.delete();
      flush();
      chk(xlog.size() == 32 && count_we() == 32, "R10", "flush traffic", xlog.size(), 32);
      chk(mem_rd(mk(4,7,5)) == 32'h5A5A_0005 && mem_rd(mk(1,5,1)) == 32'hF1F1_0001, "R10",
          "flush data", mem_rd(mk(1,5,1)), 32'hF1F1_0001);
      xlog.delete();
      flush();
      chk(xlog.size() == 0, "R10", "clean flush", xlog.size(), 0);
      xlog.delete();
      cpu_op(0, mk(4,7,5), 0, lat, fw, nat);
      chk(xlog.size() == 0, "R10", "flushed line stays valid", xlog.size(), 0);

      repeat (4) @(negedge clk);
      chk(pulse_err == 0, "R11", "ready pulse width", pulse_err, 0);
      chk(hs_err == 0, "R12", "request held to ack", hs_err, 0);
      chk(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule